// File: doc/BRIEF.md
# System Reset Sequencer with PLL Lock Gating

This block merges three reset sources into one active-low system reset. The sources are an asynchronous active-low board reset pin, a single-cycle watchdog expiry pulse and a single-cycle software reset request. It also decides when that reset is let go. The board pin pulls every reset output low at once, with no clock needed. Its release passes through a synchroniser in the system clock domain. After the release, the sequencer waits until the system PLL reports lock and then holds the system reset for a fixed number of clock cycles.

A separate PLL reset output follows only the board pin, so a watchdog or software reset never stops the PLL. Those two sources can only fire while the clock runs, so they start the hold count at once without checking lock. A new event during a hold count starts the count again. A small cause register records the source of the most recent reset. Only the board pin clears that register.

Top module: `rstgen_core`

## Requirements
- R1: While `ext_rst_n` is low, `sys_rst_n`, `rst_out_n` and `pll_rst_n` are low without waiting for a clock edge, and `rst_cause` reads 3'b001. Bit 0 means board pin, bit 1 means watchdog, bit 2 means software.
- R2: `pll_rst_n` rises on the second rising clock edge after `ext_rst_n` goes high. After that it stays high until `ext_rst_n` falls again. Watchdog and software events never lower it.
- R3: `rst_out_n` equals `sys_rst_n` in every cycle.
- R4: Call Q the first rising edge at which `pll_rst_n` is already high and `pll_locked` is high. With no further event, `sys_rst_n` rises at the eighth rising edge after Q. When the PLL is locked at release, this is the eleventh edge after the pin goes high.
- R5: While `pll_locked` stays low after release, `sys_rst_n` stays low for any length of time. The eight-edge hold starts only at the edge that sees lock.
- R6: A `wdt_pulse` or `sw_req` sampled high at edge P, while `pll_rst_n` is high, drives `sys_rst_n` low after P. With no further event it rises at edge P+8, whatever the state of `pll_locked`.
- R7: An event that arrives while the hold count is running restarts the count. `sys_rst_n` then rises eight edges after the latest event.
- R8: An accepted event loads `rst_cause` with 3'b010 for a watchdog pulse, 3'b100 for a software request, and 3'b110 when both arrive on the same edge. At all other times `rst_cause` keeps its value.
- R9: `wdt_pulse` and `sw_req` have no effect while `pll_rst_n` is low. `rst_cause` stays 3'b001 and the release timing of R4 is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | Board reset pin, active low, asynchronous |
| wdt_pulse | input | 1 | Watchdog expiry, one-cycle pulse |
| sw_req | input | 1 | Software reset request, one-cycle pulse |
| pll_locked | input | 1 | System PLL lock indication |
| sys_rst_n | output | 1 | System reset, active low |
| rst_out_n | output | 1 | Reset-out pin, follows the system reset |
| pll_rst_n | output | 1 | PLL reset, driven by the board pin only |
| rst_cause | output | 3 | Source of the most recent reset, one bit per source |

## Verification
A wrong count value or a wrong sequencer state shows up at the ports as a release of `sys_rst_n` that comes one or more cycles early or late. A sequencer stuck in its lock-wait state never releases at all. The bench compares its model against the design on every clock edge, so an error is reported on the first cycle where the release edge differs. A corrupted cause register or synchroniser stage is visible on `rst_cause` or `pll_rst_n` in the very next cycle.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_t;

  localparam int CAUSE_W   = 3;
  localparam int CAUSE_EXT = 0;
  localparam int CAUSE_WDT = 1;
  localparam int CAUSE_SW  = 2;
endpackage

// File: rtl/rstgen_sync.sv
// Release synchroniser: asynchronous assertion, clocked release.
module rstgen_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic sync_n
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh <= '0;
        else         sh <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh <= '0;
        else         sh <= {sh[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign sync_n = sh[STAGES-1];
endmodule

// File: rtl/rstgen_hold.sv
// Sequencer: waits for lock, then counts the hold window.
module rstgen_hold
  import rstgen_pkg::*;
#(
  parameter int HOLD_CYCLES = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rel_n,
  input  logic locked,
  input  logic evt,
  output logic sys_rst_n
);
  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             rst_n_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state   <= ST_WAIT;
      cnt     <= '0;
      rst_n_q <= 1'b0;
    end else if (!rel_n) begin
      state   <= ST_WAIT;
      cnt     <= '0;
      rst_n_q <= 1'b0;
    end else if (evt) begin
      state   <= ST_HOLD;
      cnt     <= '0;
      rst_n_q <= 1'b0;
    end else begin
      case (state)
        ST_WAIT: begin
          if (locked) begin
            state <= ST_HOLD;
            cnt   <= '0;
          end
        end
        ST_HOLD: begin
          if (cnt == LAST) begin
            state   <= ST_RUN;
            rst_n_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RUN: ;
        default: begin
          state   <= ST_WAIT;
          rst_n_q <= 1'b0;
        end
      endcase
    end
  end

  assign sys_rst_n = rst_n_q;
endmodule

// File: rtl/rstgen_cause.sv
// Cause register: set by the board pin, overwritten by accepted events.
module rstgen_cause
  import rstgen_pkg::*;
(
  input  logic               clk,
  input  logic               arst_n,
  input  logic               rel_n,
  input  logic               wdt,
  input  logic               sw,
  output logic [CAUSE_W-1:0] cause
);
  logic [CAUSE_W-1:0] cause_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cause_q            <= '0;
      cause_q[CAUSE_EXT] <= 1'b1;
    end else if (rel_n && (wdt || sw)) begin
      cause_q            <= '0;
      cause_q[CAUSE_WDT] <= wdt;
      cause_q[CAUSE_SW]  <= sw;
    end
  end

  assign cause = cause_q;
endmodule

// File: rtl/rstgen_core.sv
module rstgen_core #(
  parameter int HOLD_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       ext_rst_n,
  input  logic       wdt_pulse,
  input  logic       sw_req,
  input  logic       pll_locked,
  output logic       sys_rst_n,
  output logic       rst_out_n,
  output logic       pll_rst_n,
  output logic [2:0] rst_cause
);
  logic rel_n;
  logic seq_rst_n;

  rstgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (ext_rst_n),
    .sync_n (rel_n)
  );

  rstgen_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk       (clk),
    .arst_n    (ext_rst_n),
    .rel_n     (rel_n),
    .locked    (pll_locked),
    .evt       (wdt_pulse | sw_req),
    .sys_rst_n (seq_rst_n)
  );

  rstgen_cause u_cause (
    .clk    (clk),
    .arst_n (ext_rst_n),
    .rel_n  (rel_n),
    .wdt    (wdt_pulse),
    .sw     (sw_req),
    .cause  (rst_cause)
  );

  assign sys_rst_n = seq_rst_n;
  assign rst_out_n = seq_rst_n;
  assign pll_rst_n = rel_n;
endmodule

// File: rtl/rstgen_core_chk.sv
module rstgen_core_chk #(
  parameter int HOLD_CYCLES = 8
) (
  input logic       clk,
  input logic       ext_rst_n,
  input logic       wdt_pulse,
  input logic       sw_req,
  input logic       sys_rst_n,
  input logic       pll_rst_n,
  input logic [2:0] rst_cause
);
  logic [15:0] low_run;

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n)                         low_run <= '0;
    else if (sys_rst_n)                     low_run <= '0;
    else if (low_run < 16'(HOLD_CYCLES))    low_run <= low_run + 16'd1;
  end

  // R1: pin low forces every output into reset
  assert_pin_forces_reset_R1: assert property (@(posedge clk) disable iff (ext_rst_n)
    !sys_rst_n && !pll_rst_n && rst_cause == 3'b001);

  // R2: PLL reset never reasserts without the pin
  assert_pll_rst_sticky_R2: assert property (@(posedge clk) disable iff (!ext_rst_n)
    pll_rst_n |=> pll_rst_n);

  // R4: no system release before the PLL reset releases
  assert_no_early_release_R4: assert property (@(posedge clk) disable iff (!ext_rst_n)
    !pll_rst_n |-> !sys_rst_n);

  // R6: accepted event pulls system reset low
  assert_event_asserts_R6: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (wdt_pulse || sw_req) && pll_rst_n |=> !sys_rst_n);

  // R7: release only after a full hold window
  assert_full_hold_R7: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $rose(sys_rst_n) |-> low_run >= 16'(HOLD_CYCLES));

  // R8: cause changes only on an accepted event
  assert_cause_stable_R8: assert property (@(posedge clk) disable iff (!ext_rst_n)
    !((wdt_pulse || sw_req) && pll_rst_n) |=> $stable(rst_cause));

  // R8: watchdog event recorded
  assert_cause_wdt_R8: assert property (@(posedge clk) disable iff (!ext_rst_n)
    wdt_pulse && pll_rst_n |=> rst_cause[1]);
endmodule

bind rstgen_core rstgen_core_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk       (clk),
  .ext_rst_n (ext_rst_n),
  .wdt_pulse (wdt_pulse),
  .sw_req    (sw_req),
  .sys_rst_n (sys_rst_n),
  .pll_rst_n (pll_rst_n),
  .rst_cause (rst_cause)
);

// File: tb/sim_rstgen_core.sv
`timescale 1ns/1ps
module sim_rstgen_core;
  localparam int HOLD = 8;

  logic       clk = 1'b0;
  logic       ext_n = 1'b1;
  logic       wdt = 1'b0;
  logic       sw = 1'b0;
  logic       locked = 1'b1;
  logic       sys_rst_n, rst_out_n, pll_rst_n;
  logic [2:0] cause;

  int checks = 0;
  int fails = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;
  string cur_req = "R4";

  always #10 clk = ~clk;

  rstgen_core #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) u0 (
    .clk(clk), .ext_rst_n(ext_n), .wdt_pulse(wdt), .sw_req(sw),
    .pll_locked(locked), .sys_rst_n(sys_rst_n), .rst_out_n(rst_out_n),
    .pll_rst_n(pll_rst_n), .rst_cause(cause)
  );

  // behavioural reference model
  bit       m_s1 = 0, m_s2 = 0, m_sys = 0, m_wait = 1, p_s2 = 0;
  int       m_left = 0;
  logic [2:0] m_cause = 3'b001;

  always @(negedge ext_n) begin
    m_s1 = 0; m_s2 = 0; m_sys = 0; m_wait = 1; m_left = 0; m_cause = 3'b001;
  end

  always @(posedge clk) begin
    if (ext_n) begin
      p_s2 = m_s2;
      m_s2 = m_s1;
      m_s1 = 1;
      if (p_s2) begin
        if (wdt || sw) begin
          m_cause = {sw, wdt, 1'b0};
          m_left = HOLD; m_wait = 0; m_sys = 0;
        end else if (m_wait) begin
          if (locked) begin m_wait = 0; m_left = HOLD; end
        end else if (m_left > 0) begin
          m_left = m_left - 1;
          if (m_left == 0) m_sys = 1;
        end
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (cmp_en) begin
      check(cur_req, "sys_rst_n", sys_rst_n, m_sys);
      check("R3", "rst_out_n", rst_out_n, sys_rst_n);
      check("R2", "pll_rst_n", pll_rst_n, m_s2);
      check("R8", "rst_cause", cause, m_cause);
    end
  end

  // counts rising edges from now until sys_rst_n is high
  task automatic edges_to_release(output int n);
    n = -1;
    for (int i = 1; i <= 60; i++) begin
      @(posedge clk); #1;
      if (sys_rst_n) begin n = i; break; end
    end
  endtask

  task automatic pulse(input bit w, input bit s);
    @(negedge clk);
    wdt = w; sw = s;
    @(negedge clk);
    wdt = 0; sw = 0;
  endtask

  initial begin
    int n;
    #1 ext_n = 1'b0;
    #1;
    check("R1", "sys low at pin", sys_rst_n, 0);
    check("R1", "pll low at pin", pll_rst_n, 0);
    check("R1", "cause at pin", cause, 3'b001);
    cmp_en = 1'b1;
    repeat (3) @(negedge clk);

    // R4 / R2: locked release
    cur_req = "R4";
    ext_n = 1'b1;
    n = -1;
    for (int i = 1; i <= 4; i++) begin
      @(posedge clk); #1;
      if (pll_rst_n && n < 0) n = i;
    end
    check("R2", "edges to pll release", n, 2);
    edges_to_release(n);
    check("R4", "edges to sys release", n + 4, 11);
    repeat (3) @(negedge clk);

    // R6: watchdog pulse
    cur_req = "R6";
    @(negedge clk); wdt = 1;
    @(negedge clk); wdt = 0;
    check("R6", "sys low after wdt", sys_rst_n, 0);
    check("R2", "pll kept after wdt", pll_rst_n, 1);
    check("R8", "cause wdt", cause, 3'b010);
    edges_to_release(n);
    check("R6", "wdt hold edges", n + 1, 9);

    // R6 with lock low: event does not wait for lock
    locked = 0;
    pulse(0, 1);
    check("R8", "cause sw", cause, 3'b100);
    edges_to_release(n);
    check("R6", "sw hold edges unlocked", n + 1, 9);
    locked = 1;

    // both on one edge
    pulse(1, 1);
    check("R8", "cause both", cause, 3'b110);
    edges_to_release(n);

    // R7: restart during hold
    cur_req = "R7";
    pulse(1, 0);
    repeat (3) @(negedge clk);
    pulse(0, 1);
    check("R7", "cause after restart", cause, 3'b100);
    edges_to_release(n);
    check("R7", "restart hold edges", n + 1, 9);

    // R5: release with PLL unlocked
    cur_req = "R5";
    @(negedge clk); locked = 0; ext_n = 0;
    #1 check("R1", "sys low at pin again", sys_rst_n, 0);
    check("R1", "cause reset by pin", cause, 3'b001);
    repeat (2) @(negedge clk);
    ext_n = 1;
    repeat (30) @(negedge clk);
    #1 check("R5", "held while unlocked", sys_rst_n, 0);
    @(negedge clk); locked = 1;
    edges_to_release(n);
    check("R5", "edges after lock", n, 9);

    // R9: events while pin low or during sync are ignored
    cur_req = "R9";
    @(negedge clk); ext_n = 0;
    pulse(1, 0);
    @(negedge clk); ext_n = 1;
    wdt = 1;
    @(negedge clk); wdt = 0; sw = 1;
    @(negedge clk); sw = 0;
    #1 check("R9", "cause unchanged", cause, 3'b001);
    edges_to_release(n);
    check("R9", "release timing", n + 2, 11);
    repeat (4) @(negedge clk);

    cmp_en = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule